// File: doc/BRIEF.md
# SD Command-Line Engine

This block drives the host side of the SD command line. A single `start` pulse loads a command index, a 32-bit argument and a response kind. The engine then shifts a 48-bit command frame out on CMD, most significant bit first, one bit per clock, and generates its CRC7 while sending. After the end bit it releases the line. It then waits for the card's start bit and captures a response of the selected length. It checks the response and ends with a one-cycle `done` pulse that carries a two-bit status and the response payload.

There are four response kinds. A kind with no response finishes as soon as the frame is out. A checked short response (48 bits) is tested for CRC7 and for the echoed index. A raw short response (48 bits) is returned without any check, which suits replies that carry no valid CRC. A long response (136 bits) is tested for CRC7 over its 15 payload bytes and for a fixed 0x3F header byte. A cycle-count timeout bounds the wait for the start bit, and after a timeout the engine is idle again.

The controller has seven states. `ST_IDLE` goes to `ST_SEND` on `start`. `ST_SEND` goes to `ST_TURN` after bit 47, or to `ST_DONE` when no response is expected. `ST_TURN` goes to `ST_WAIT` after `TURN_CYC` cycles. `ST_WAIT` goes to `ST_RECV` on a 1-to-0 edge of CMD, or to `ST_DONE` on timeout. `ST_RECV` goes to `ST_EVAL` after the last response bit. `ST_EVAL` goes to `ST_DONE`. `ST_DONE` returns to `ST_IDLE`.

Top module: `sdcmd_engine`

## Requirements
- R1: While `cmd_oe` is high, which lasts exactly 48 cycles after `start`, `cmd_out` carries, MSB first: a 0 start bit, a 1 direction bit, the 6-bit index, the 32-bit argument (MSB first), 7 CRC bits, and a 1 end bit.
- R2: The 7 CRC bits (frame bits 7..1) are the CRC7 with generator x^7+x^3+1 over the first 40 frame bits in send order. The register starts from zero.
- R3: After the end bit, `cmd_oe` stays low for at least two cycles before a start bit is accepted. With kind 0 (no response), `done` follows with status 0 and `rsp_data` is zero.
- R4: A response starts at the first 1-to-0 transition of `cmd_in` seen in `ST_WAIT`. It is 48 bits long for kinds 1 and 2 and 136 bits long for kind 3.
- R5: For kind 1, status 2 (CRC error) is reported when the CRC7 over the first 40 response bits differs from response bits 7..1. The end bit (bit 0) is ignored.
- R6: For kind 1 with a good CRC, status 3 (index error) is reported when response bits 45..40 differ from the issued index, unless the issued index is 41. A CRC error takes precedence over an index error.
- R7: For kind 2, status 0 is reported whatever the CRC and index fields hold.
- R8: For kind 3, status 2 is reported when the CRC7 over response bits 127..8 differs from bits 7..1. Otherwise, status 3 is reported when the header byte (bits 135..128) is not 0x3F.
- R9: Whenever a response is received, `rsp_data` holds, whatever the status: for short kinds, response bits 39..8 in `rsp_data[31:0]` with the upper bits zero; for the long kind, response bits 127..8.
- R10: If no start bit arrives within `TIMEOUT_CYC` cycles in `ST_WAIT`, status 1 is reported with `rsp_data` zero, and the next command runs normally.
- R11: After reset, `cmd_oe`, `busy`, `done`, `status` and `rsp_data` are zero and `cmd_out` is 1.
- R12: `done` is a one-cycle pulse. `busy` rises in the cycle after `start` and falls in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SD clock; one CMD bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a command (taken in idle) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 0 none, 1 short checked, 2 short raw, 3 long |
| cmd_in | input | 1 | Sampled CMD line |
| cmd_out | output | 1 | Value driven on CMD |
| cmd_oe | output | 1 | CMD driver enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 OK, 1 timeout, 2 CRC error, 3 index error |
| rsp_data | output | 120 | Response payload |

## Verification
A wrong bit counter or a shifter that slips by one shows up within the 48 driven cycles as a misplaced index, argument, CRC or end bit on `cmd_out`. Errors in the turnaround or in start-bit detection show up as `cmd_oe` rising too early, or as a payload shifted by one bit in `rsp_data` at the `done` pulse. A fault in the CRC register or in the check order leaves the payload correct but the status code wrong, and this is visible in the same cycle as `done`. A stuck timeout counter shows up as `done` missing or arriving early after a silent card.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_SEND, ST_TURN, ST_WAIT, ST_RECV, ST_EVAL, ST_DONE
    } eng_state_t;

    localparam logic [1:0] KIND_NONE  = 2'd0;
    localparam logic [1:0] KIND_SHORT = 2'd1;
    localparam logic [1:0] KIND_RAW   = 2'd2;
    localparam logic [1:0] KIND_LONG  = 2'd3;

    localparam logic [1:0] STAT_OK      = 2'd0;
    localparam logic [1:0] STAT_TIMEOUT = 2'd1;
    localparam logic [1:0] STAT_CRC     = 2'd2;
    localparam logic [1:0] STAT_INDEX   = 2'd3;

    localparam int CRC_W      = 7;
    localparam int FRAME_BITS = 48;
    localparam int BODY_BITS  = FRAME_BITS - CRC_W - 1;
    localparam int LONG_BITS  = 136;
    localparam int HDR_BITS   = 8;
    localparam int LONG_PAY_W = LONG_BITS - 2 * HDR_BITS;
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7 #(
    parameter int             W    = 7,
    parameter logic [W-1:0]   POLY = 7'h09
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc_o
);
    logic fb;
    assign fb = din ^ crc_o[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            crc_o <= '0;
        else if (clr)
            crc_o <= '0;
        else if (en)
            crc_o <= {crc_o[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
    end

    // R2: every frame's CRC starts from an all-zero register
    assert_crc_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_o == '0));
endmodule

// File: rtl/sdcmd_timeout.sv
module sdcmd_timeout #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && cnt != CW'(LIMIT - 1))
            cnt <= cnt + 1'b1;
    end

    assign expired_o = en && (cnt == CW'(LIMIT - 1));

    // R10: the wait window never runs past its limit
    assert_window_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int         TIMEOUT_CYC = 64,
    parameter int         TURN_CYC    = 2,
    parameter logic [5:0] EXEMPT_IDX  = 6'd41,
    parameter logic [7:0] LONG_HDR    = 8'h3F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [5:0]            cmd_idx,
    input  logic [31:0]           cmd_arg,
    input  logic [1:0]            rsp_kind,
    input  logic                  cmd_in,
    output logic                  cmd_out,
    output logic                  cmd_oe,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            status,
    output logic [LONG_PAY_W-1:0] rsp_data
);
    localparam logic [7:0] LAST_TX   = 8'(FRAME_BITS - 1);
    localparam logic [7:0] CRC_LO    = 8'(BODY_BITS);
    localparam logic [7:0] LAST_CRC  = 8'(FRAME_BITS - 2);
    localparam logic [7:0] LAST_TURN = 8'(TURN_CYC - 1);
    localparam logic [7:0] LONG_LO   = 8'(HDR_BITS);
    localparam logic [7:0] LONG_HI   = 8'(LONG_BITS - HDR_BITS);

    eng_state_t            state_q, state_d;
    logic [7:0]            bit_cnt;
    logic [BODY_BITS-1:0]  frame_q;
    logic [1:0]            kind_q;
    logic [5:0]            idx_q;
    logic [LONG_BITS-1:0]  rx_sr;
    logic                  prev_in;
    logic [1:0]            status_q, stat_next;
    logic [LONG_PAY_W-1:0] rsp_q, rsp_next;
    logic [CRC_W-1:0]      crc_q;
    logic                  crc_clr, crc_en, crc_din;
    logic                  tmo, fall, crc_ok;
    logic [7:0]            rx_last;
    logic [2:0]            crc_sel;
    logic                  unused_bits;

    assign fall        = prev_in && !cmd_in;
    assign rx_last     = (kind_q == KIND_LONG) ? 8'(LONG_BITS - 1) : LAST_TX;
    assign crc_sel     = 3'(LAST_CRC - bit_cnt);
    assign crc_ok      = (rx_sr[CRC_W:1] == crc_q);
    assign unused_bits = rx_sr[0];

    sdcmd_crc7 #(.W(CRC_W), .POLY(7'h09)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en),
        .din(crc_din), .crc_o(crc_q)
    );

    sdcmd_timeout #(.LIMIT(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(state_q != ST_WAIT),
        .en(state_q == ST_WAIT), .expired_o(tmo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SEND;
            ST_SEND: if (bit_cnt == LAST_TX)
                         state_d = (kind_q == KIND_NONE) ? ST_DONE : ST_TURN;
            ST_TURN: if (bit_cnt == LAST_TURN) state_d = ST_WAIT;
            ST_WAIT: if (fall) state_d = ST_RECV;
                     else if (tmo) state_d = ST_DONE;
            ST_RECV: if (bit_cnt == rx_last) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != state_d)
                bit_cnt <= (state_d == ST_RECV) ? 8'd1 : 8'd0;
            else if (state_q inside {ST_SEND, ST_TURN, ST_RECV})
                bit_cnt <= bit_cnt + 8'd1;
        end
    end

    // CRC feed: transmit body, or the covered span of the response
    always_comb begin
        crc_clr = (state_q == ST_IDLE && start) || (state_q == ST_WAIT && fall);
        crc_din = (state_q == ST_SEND) ? frame_q[BODY_BITS-1] : cmd_in;
        crc_en  = 1'b0;
        if (state_q == ST_SEND)
            crc_en = bit_cnt < CRC_LO;
        else if (state_q == ST_RECV)
            crc_en = (kind_q == KIND_LONG) ? (bit_cnt >= LONG_LO && bit_cnt < LONG_HI)
                                           : (bit_cnt < CRC_LO);
    end

    // response evaluation, CRC before index
    always_comb begin
        stat_next = STAT_OK;
        rsp_next  = {{(LONG_PAY_W-32){1'b0}}, rx_sr[39:8]};
        unique case (kind_q)
            KIND_SHORT: begin
                if (!crc_ok)
                    stat_next = STAT_CRC;
                else if (rx_sr[45:40] != idx_q && idx_q != EXEMPT_IDX)
                    stat_next = STAT_INDEX;
            end
            KIND_LONG: begin
                rsp_next = rx_sr[LONG_BITS-HDR_BITS-1:HDR_BITS];
                if (!crc_ok)
                    stat_next = STAT_CRC;
                else if (rx_sr[LONG_BITS-1:LONG_BITS-HDR_BITS] != LONG_HDR)
                    stat_next = STAT_INDEX;
            end
            default: stat_next = STAT_OK;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q  <= '0;
            kind_q   <= KIND_NONE;
            idx_q    <= '0;
            rx_sr    <= '0;
            prev_in  <= 1'b1;
            status_q <= STAT_OK;
            rsp_q    <= '0;
        end else begin
            prev_in <= cmd_in;
            if (state_q == ST_IDLE && start) begin
                frame_q  <= {1'b0, 1'b1, cmd_idx, cmd_arg};
                kind_q   <= rsp_kind;
                idx_q    <= cmd_idx;
                rx_sr    <= '0;
                status_q <= STAT_OK;
                rsp_q    <= '0;
            end
            if (state_q == ST_SEND)
                frame_q <= {frame_q[BODY_BITS-2:0], 1'b0};
            if ((state_q == ST_WAIT && fall) || state_q == ST_RECV)
                rx_sr <= {rx_sr[LONG_BITS-2:0], cmd_in};
            if (state_q == ST_WAIT && !fall && tmo)
                status_q <= STAT_TIMEOUT;
            if (state_q == ST_EVAL) begin
                status_q <= stat_next;
                rsp_q    <= rsp_next;
            end
        end
    end

    // port outputs
    always_comb begin
        cmd_oe   = (state_q == ST_SEND);
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        status   = status_q;
        rsp_data = rsp_q;
        cmd_out  = 1'b1;
        if (state_q == ST_SEND) begin
            if (bit_cnt < CRC_LO)
                cmd_out = frame_q[BODY_BITS-1];
            else if (bit_cnt < LAST_TX)
                cmd_out = crc_q[crc_sel];
        end
    end

    // R1: the last driven bit before release is the end bit
    assert_end_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));
    // R3: line stays released in the cycle after the drive ends
    assert_turn_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |=> !cmd_oe);
    // R4: reception begins only on a sampled high-to-low edge
    assert_rx_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && $past(state_q) == ST_WAIT) |-> ($past(prev_in) && !$past(cmd_in)));
    // R9: result stays put between commands
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> ($stable(status) && $stable(rsp_data)));
    // R12: completion is a single-cycle pulse and busy only follows a start
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

// File: tb/sim_sdcmd_engine.sv
`timescale 1ns/1ps
module sim_sdcmd_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [5:0]   cmd_idx = '0;
    logic [31:0]  cmd_arg = '0;
    logic [1:0]   rsp_kind = '0;
    logic         cmd_in = 1'b1;
    logic         cmd_out, cmd_oe, busy, done;
    logic [1:0]   status;
    logic [119:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdcmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .cmd_in(cmd_in),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
        .status(status), .rsp_data(rsp_data)
    );

    typedef struct packed {
        logic [5:0]  idx;
        logic [31:0] arg;
        logic [1:0]  kind;
        logic [7:0]  hdr;
        logic        flip;
        logic        silent;
        logic        end0;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{6'd17, 32'h0000_1234, 2'd1, 8'd17,  1'b0, 1'b0, 1'b0, 2'd0}, // R5 R6 good short
        '{6'd55, 32'hDEAD_BEEF, 2'd1, 8'd13,  1'b0, 1'b0, 1'b0, 2'd3}, // R6 index mismatch
        '{6'd41, 32'h40FF_8000, 2'd1, 8'd63,  1'b0, 1'b0, 1'b0, 2'd0}, // R6 exempt index
        '{6'd8,  32'h0000_01AA, 2'd1, 8'd8,   1'b1, 1'b0, 1'b0, 2'd2}, // R5 bad crc
        '{6'd41, 32'h00FF_8000, 2'd2, 8'd63,  1'b1, 1'b0, 1'b0, 2'd0}, // R7 raw
        '{6'd2,  32'h0000_0000, 2'd3, 8'h3F,  1'b0, 1'b0, 1'b0, 2'd0}, // R8 good long
        '{6'd9,  32'h1357_9BDF, 2'd3, 8'h3E,  1'b0, 1'b0, 1'b0, 2'd3}, // R8 bad header
        '{6'd10, 32'hCAFE_F00D, 2'd3, 8'h3F,  1'b1, 1'b0, 1'b0, 2'd2}, // R8 bad crc
        '{6'd0,  32'h0000_0000, 2'd0, 8'd0,   1'b0, 1'b0, 1'b0, 2'd0}, // R3 no response
        '{6'd12, 32'h0001_0000, 2'd1, 8'd12,  1'b0, 1'b1, 1'b0, 2'd1}, // R10 silent card
        '{6'd13, 32'h8000_0001, 2'd1, 8'd13,  1'b0, 1'b0, 1'b1, 2'd0}, // R5 end bit ignored, R10 recovery
        '{6'd55, 32'h7777_0001, 2'd1, 8'd7,   1'b1, 1'b0, 1'b0, 2'd2}, // R6 crc precedence
        '{6'd63, 32'hFFFF_FFFF, 2'd1, 8'd63,  1'b0, 1'b0, 1'b0, 2'd0}  // R1 all ones
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_of(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    task automatic run_vec(input vec_t v, input int k);
        logic [47:0]  got = '0;
        logic [39:0]  body;
        logic [119:0] pay;
        logic [135:0] resp = '0;
        logic [119:0] exp_rsp = '0;
        logic [31:0]  st32;
        int nb = 0;
        int rlen;
        int w = 0;
        body = {2'b01, v.idx, v.arg};
        st32 = v.arg ^ 32'hA5A5_0F0F;
        pay  = {v.arg, ~v.arg, v.arg ^ 32'h1234_5678, v.arg[23:0]};
        if (v.kind == 2'd3) begin
            rlen = 136;
            resp = {v.hdr, pay, crc7_of({16'h0, pay}, 120) ^ {6'b0, v.flip}, ~v.end0};
            exp_rsp = pay;
        end else begin
            logic [39:0] rb;
            rlen = 48;
            rb   = {2'b00, v.hdr[5:0], st32};
            resp = {88'h0, rb, crc7_of({96'h0, rb}, 40) ^ {6'b0, v.flip}, ~v.end0};
            exp_rsp = {88'h0, st32};
        end
        if (v.kind == 2'd0 || v.silent) exp_rsp = '0;

        @(negedge clk);
        cmd_idx = v.idx; cmd_arg = v.arg; rsp_kind = v.kind; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, $sformatf("R12 busy after start v%0d", k), busy, 1);
        while (cmd_oe && nb < 60) begin
            got = {got[46:0], cmd_out};
            nb++;
            @(negedge clk);
        end
        chk(nb == 48, $sformatf("R1 drive length v%0d", k), nb, 48);
        chk({got[47:8], got[0]} === {body, 1'b1}, $sformatf("R1 frame fields v%0d", k),
            {got[47:8], got[0]}, {body, 1'b1});
        chk(got[7:1] === crc7_of({96'h0, body}, 40), $sformatf("R2 frame crc v%0d", k),
            got[7:1], crc7_of({96'h0, body}, 40));
        if (v.kind != 2'd0) begin
            chk(cmd_oe === 1'b0, $sformatf("R3 release gap1 v%0d", k), cmd_oe, 0);
            @(negedge clk);
            chk(cmd_oe === 1'b0, $sformatf("R3 release gap2 v%0d", k), cmd_oe, 0);
            @(negedge clk);
            @(negedge clk);
            if (!v.silent) begin
                for (int i = 0; i < rlen; i++) begin
                    cmd_in = resp[rlen - 1 - i];
                    @(negedge clk);
                end
                cmd_in = 1'b1;
            end
        end
        while (!done && w < 500) begin
            @(negedge clk);
            w++;
        end
        chk(done === 1'b1, $sformatf("R12 done seen v%0d", k), done, 1);
        chk(status === v.exp, $sformatf("R4-status R%0s v%0d",
            (v.kind == 2'd3) ? "8" : (v.silent ? "10" : "5"), k), status, v.exp);
        chk(rsp_data === exp_rsp, $sformatf("R9 payload v%0d", k), rsp_data, exp_rsp);
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, $sformatf("R12 pulse end v%0d", k),
            {done, busy}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(cmd_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R11 idle flags",
            {cmd_oe, busy, done}, 3'b000);
        chk(cmd_out === 1'b1, "R11 line high", cmd_out, 1);
        chk(status === 2'd0 && rsp_data === '0, "R11 result cleared",
            {status, rsp_data}, '0);
        for (int k = 0; k < NV; k++) run_vec(VEC[k], k);
        // R10 a second silent wait, then a good command back to back
        run_vec(VEC[9], 100);
        run_vec(VEC[0], 101);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R12 watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule